// File: doc/BRIEF.md
# Multi-Sensor Thermal Trip Comparator

This block watches four temperature channels: a CPU sensor (index 0), a memory sensor (index 1), a GPU sensor (index 2) and a PLL sensor (index 3). Each channel has two thresholds, both in millidegrees Celsius. The lower one is the throttle limit. A reading above it raises a throttle request for that channel. The request drops only after the reading falls below the limit minus a shared hysteresis margin. The upper one is the shutdown limit. A reading at or above it sets a sticky cause bit. The OR of all cause bits drives a single trigger toward the external power-management device, which then resets or powers down the system.

Readings arrive as signed 32-bit values, each with its own valid strobe. Every channel has an enable bit. Only readings that are both valid and enabled are compared. All state is registered. The outputs reflect a reading on the clock edge that captures it.

Top module: `therm_trip_unit`

## Requirements
- R1: After reset, `throttleReq`, `shutdownTrig` and `statusWord` are all zero.
- R2: A valid reading on an enabled channel that is strictly greater than that channel's throttle limit sets its throttle request. A reading equal to the limit does not set it.
- R3: A set throttle request clears only when a valid, enabled reading is strictly below (throttle limit minus `hystMargin`). Readings between that value and the limit leave the request unchanged.
- R4: A valid, enabled reading greater than or equal to the channel's shutdown limit sets that channel's shutdown cause bit. The bit stays set until reset, whatever later readings or enables do.
- R5: `shutdownTrig` is the OR of the four shutdown cause bits. Once high, it stays high until reset.
- R6: A reading whose valid strobe is low changes neither the throttle request nor the shutdown cause bit of its channel.
- R7: While a channel's enable bit is low, its throttle request is cleared on the next edge, and its readings cannot set its shutdown cause bit.
- R8: All comparisons are two's-complement signed, so readings and limits below zero order correctly.
- R9: Each channel's state depends only on its own reading, strobe, enable and limits.
- R10: `statusWord[3:0]` holds the throttle requests and `statusWord[7:4]` holds the shutdown cause bits, with bit position n+0 and n+4 belonging to channel n.
- R11: A reading captured on a clock edge shows on the outputs right after that same edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sampleTemp | input | 128 | Signed readings, channel n at bits [32n+31:32n] |
| sampleValid | input | 4 | Per-channel reading strobe |
| chanEnable | input | 4 | Per-channel enable |
| hotLimit | input | 128 | Signed throttle limits, same packing as sampleTemp |
| tripLimit | input | 128 | Signed shutdown limits, same packing |
| hystMargin | input | 32 | Release hysteresis, non-negative |
| throttleReq | output | 4 | Per-channel throttle request |
| shutdownTrig | output | 1 | Trigger to the power-management device |
| statusWord | output | 8 | {shutdown cause bits, throttle requests} |

## Verification
On every cycle, the assertions check these properties: shutdown cause bits and the trigger never fall, a throttle request rises only after a qualified reading, a disabled channel's request is low one edge later, and an invalid reading leaves the channel's state untouched. Only the directed scenarios can show the exact thresholds at work. These cover the strict comparison at the throttle limit, the inclusive comparison at the shutdown limit, the hold band inside the hysteresis, negative readings, and the bit placement of the status word.

// File: rtl/therm_trip_pkg.sv
package therm_trip_pkg;

  // Compare results for one channel, produced by the datapath
  typedef struct packed {
    logic overHot;      // reading > throttle limit
    logic underRelease; // reading < throttle limit - hysteresis
    logic atTrip;       // reading >= shutdown limit
  } chanCmp_t;

  // Update strobes for one channel, produced by the control
  typedef struct packed {
    logic hotSet;
    logic hotClr;
    logic tripSet;
  } chanStrobe_t;

endpackage

// File: rtl/therm_trip_ctrl.sv
module therm_trip_ctrl
  import therm_trip_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        sampleValid,
  input  logic [NUM_CH-1:0]        chanEnable,
  input  chanCmp_t [NUM_CH-1:0]    cmp,
  output chanStrobe_t [NUM_CH-1:0] strb
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_qual
    logic qualified;
    assign qualified       = sampleValid[i] & chanEnable[i];
    assign strb[i].hotSet  = qualified & cmp[i].overHot;
    assign strb[i].hotClr  = ~chanEnable[i] | (qualified & cmp[i].underRelease);
    assign strb[i].tripSet = qualified & cmp[i].atTrip;

    // R7
    disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chanEnable[i] |-> !strb[i].hotSet && !strb[i].tripSet);
  end

endmodule

// File: rtl/therm_trip_dp.sv
module therm_trip_dp
  import therm_trip_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TEMP_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*TEMP_W-1:0] sampleTemp,
  input  logic [NUM_CH*TEMP_W-1:0] hotLimit,
  input  logic [NUM_CH*TEMP_W-1:0] tripLimit,
  input  logic [TEMP_W-1:0]        hystMargin,
  input  chanStrobe_t [NUM_CH-1:0] strb,
  output chanCmp_t [NUM_CH-1:0]    cmp,
  output logic [NUM_CH-1:0]        hotQ,
  output logic [NUM_CH-1:0]        tripQ
);

  localparam int EXT_W = TEMP_W + 1;

  logic signed [EXT_W-1:0] hystX;
  assign hystX = EXT_W'($signed(hystMargin));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic signed [EXT_W-1:0] tempX, hotX, relX, tripX;

    assign tempX = EXT_W'($signed(sampleTemp[i*TEMP_W +: TEMP_W]));
    assign hotX  = EXT_W'($signed(hotLimit[i*TEMP_W +: TEMP_W]));
    assign tripX = EXT_W'($signed(tripLimit[i*TEMP_W +: TEMP_W]));
    assign relX  = hotX - hystX;

    assign cmp[i].overHot      = tempX > hotX;
    assign cmp[i].underRelease = tempX < relX;
    assign cmp[i].atTrip       = tempX >= tripX;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hotQ[i]  <= 1'b0;
        tripQ[i] <= 1'b0;
      end else begin
        if (strb[i].hotSet)      hotQ[i] <= 1'b1;
        else if (strb[i].hotClr) hotQ[i] <= 1'b0;
        if (strb[i].tripSet)     tripQ[i] <= 1'b1;
      end
    end

    // R4
    trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tripQ[i] |=> tripQ[i]);

    // R3
    hot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hotQ[i]) |-> $past(strb[i].hotClr));
  end

endmodule

// File: rtl/therm_trip_unit.sv
module therm_trip_unit
  import therm_trip_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TEMP_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*TEMP_W-1:0] sampleTemp,
  input  logic [NUM_CH-1:0]        sampleValid,
  input  logic [NUM_CH-1:0]        chanEnable,
  input  logic [NUM_CH*TEMP_W-1:0] hotLimit,
  input  logic [NUM_CH*TEMP_W-1:0] tripLimit,
  input  logic [TEMP_W-1:0]        hystMargin,
  output logic [NUM_CH-1:0]        throttleReq,
  output logic                     shutdownTrig,
  output logic [2*NUM_CH-1:0]      statusWord
);

  chanCmp_t    [NUM_CH-1:0] cmp;
  chanStrobe_t [NUM_CH-1:0] strb;
  logic        [NUM_CH-1:0] hotQ;
  logic        [NUM_CH-1:0] tripQ;

  therm_trip_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleValid (sampleValid),
    .chanEnable  (chanEnable),
    .cmp         (cmp),
    .strb        (strb)
  );

  therm_trip_dp #(.NUM_CH(NUM_CH), .TEMP_W(TEMP_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleTemp (sampleTemp),
    .hotLimit   (hotLimit),
    .tripLimit  (tripLimit),
    .hystMargin (hystMargin),
    .strb       (strb),
    .cmp        (cmp),
    .hotQ       (hotQ),
    .tripQ      (tripQ)
  );

  assign throttleReq  = hotQ;
  assign shutdownTrig = |tripQ;
  assign statusWord   = {tripQ, hotQ};

  // R5
  shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdownTrig |=> shutdownTrig);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6
    invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sampleValid[i] && chanEnable[i]) |=>
        $stable(throttleReq[i]) && $stable(statusWord[NUM_CH+i]));

    // R7
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chanEnable[i] |=> !throttleReq[i]);

    // R2
    throttle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(throttleReq[i]) |-> $past(sampleValid[i] && chanEnable[i]));
  end

endmodule

// File: tb/sim_therm_trip_unit.sv
`timescale 1ns/1ps
module sim_therm_trip_unit;

  localparam int NCH = 4;
  localparam int TW  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*TW-1:0] sampleTemp = '0;
  logic [NCH-1:0]    sampleValid = '0;
  logic [NCH-1:0]    chanEnable = '1;
  logic [NCH*TW-1:0] hotLimit = '0;
  logic [NCH*TW-1:0] tripLimit = '0;
  logic [TW-1:0]     hystMargin = 32'd1000;
  logic [NCH-1:0]    throttleReq;
  logic              shutdownTrig;
  logic [2*NCH-1:0]  statusWord;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk; // 250 MHz

  therm_trip_unit #(.NUM_CH(NCH), .TEMP_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .sampleTemp(sampleTemp), .sampleValid(sampleValid),
    .chanEnable(chanEnable), .hotLimit(hotLimit), .tripLimit(tripLimit),
    .hystMargin(hystMargin), .throttleReq(throttleReq),
    .shutdownTrig(shutdownTrig), .statusWord(statusWord)
  );

  task automatic chk(string req, longint act, longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setLimits(int ch, int hot, int trip);
    hotLimit[ch*TW +: TW]  = hot;
    tripLimit[ch*TW +: TW] = trip;
  endtask

  // present one reading per listed channel for one edge, then check after it
  task automatic drive(int ch, int temp, bit valid);
    @(negedge clk);
    sampleTemp[ch*TW +: TW] = temp;
    sampleValid = '0;
    sampleValid[ch] = valid;
    @(posedge clk); #1;
    sampleValid = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    chk("R1 throttleReq", throttleReq, 0);
    chk("R1 shutdownTrig", shutdownTrig, 0);
    chk("R1 statusWord", statusWord, 0);
  endtask

  task automatic tThrottle();
    drive(0, 100000, 1);
    chk("R2 equal does not set", throttleReq[0], 0);
    drive(0, 100001, 1);
    chk("R2/R11 above sets same edge", throttleReq[0], 1);
    chk("R10 status bit0", statusWord, 8'h01);
    drive(0, 99500, 1);
    chk("R3 hold band", throttleReq[0], 1);
    drive(0, 99000, 1);
    chk("R3 at release point holds", throttleReq[0], 1);
    drive(0, 98999, 1);
    chk("R3 below release clears", throttleReq[0], 0);
  endtask

  task automatic tInvalid();
    drive(0, 150000, 0);
    chk("R6 invalid no throttle", throttleReq[0], 0);
    chk("R6 invalid no trip", statusWord, 8'h00);
    drive(0, 100500, 1);
    drive(0, 0, 0);
    chk("R6 invalid no release", throttleReq[0], 1);
    drive(0, 0, 1);
    chk("R3 release after cool", throttleReq[0], 0);
  endtask

  task automatic tDisable();
    drive(2, 100500, 1);
    chk("R2 ch2 set", throttleReq[2], 1);
    @(negedge clk); chanEnable[2] = 1'b0;
    @(posedge clk); #1;
    chk("R7 disable clears", throttleReq[2], 0);
    drive(2, 200000, 1);
    chk("R7 disabled no trip", statusWord[6], 0);
    chk("R7 disabled no throttle", throttleReq[2], 0);
    chk("R7 trigger low", shutdownTrig, 0);
    @(negedge clk); chanEnable[2] = 1'b1;
    drive(2, 0, 1);
  endtask

  task automatic tSigned();
    setLimits(1, -5000, 50000);
    drive(1, -4000, 1);
    chk("R8 negative above limit sets", throttleReq[1], 1);
    drive(1, -6000, 1);
    chk("R8 negative hold band", throttleReq[1], 1);
    drive(1, -6001, 1);
    chk("R8 negative release", throttleReq[1], 0);
    drive(1, -200000, 1);
    chk("R8 very cold no trip", statusWord[5], 0);
  endtask

  task automatic tMulti();
    @(negedge clk);
    sampleTemp[0*TW +: TW] = 100700;
    sampleTemp[2*TW +: TW] = 50000;
    sampleValid = 4'b0101;
    @(posedge clk); #1;
    sampleValid = '0;
    chk("R9 ch0 set", throttleReq[0], 1);
    chk("R9 ch2 untouched", throttleReq[2], 0);
    chk("R9 status", statusWord, 8'h01);
    drive(0, 0, 1);
  endtask

  task automatic tTrip();
    drive(3, 102999, 1);
    chk("R4 below trip", shutdownTrig, 0);
    chk("R2 ch3 throttles", throttleReq[3], 1);
    drive(3, 103000, 1);
    chk("R4/R11 equal trips", shutdownTrig, 1);
    chk("R10 status ch3", statusWord, 8'h88);
    drive(3, 0, 1);
    chk("R4 sticky after cool", statusWord[7], 1);
    chk("R5 trigger sticky", shutdownTrig, 1);
    @(negedge clk); chanEnable[3] = 1'b0;
    @(posedge clk); #1;
    chk("R4 sticky after disable", statusWord, 8'h80);
    @(negedge clk); chanEnable[3] = 1'b1;
    drive(0, 102500, 1);
    chk("R5 two causes", statusWord, 8'h91);
    chk("R5 trigger OR", shutdownTrig, 1);
    doReset();
    chk("R4 reset clears cause", statusWord, 8'h00);
    chk("R5 reset clears trigger", shutdownTrig, 0);
  endtask

  initial begin
    setLimits(0, 100000, 102500);
    setLimits(1, 100000, 102500);
    setLimits(2, 100000, 103000);
    setLimits(3, 100000, 103000);
    tReset();
    tThrottle();
    tInvalid();
    tDisable();
    tSigned();
    tMulti();
    tTrip();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule